// File: doc/BRIEF.md
# Credit-Paced Write Streamer

This block sits on the host side of a bus and moves one whole message, word by word, from a local data source to a single fixed target address. It does this as a run of back-to-back single-word writes. The target's write queue can fill up. Backing off when the target drops its request-ready is too late, because the next write has already been launched. The streamer therefore paces itself on a credit value. The target returns this value in the user field of every write response: it is the number of words the target can still take.

A command is a single pulse of `start_i` with a word count and a destination address, and it covers the whole message. Before it sends any data, and again whenever its working credit is used up while words remain, the streamer sends a probe. A probe is a write to the same address with every byte-enable cleared, and its response carries a fresh credit value. While the streamer waits for credit, it keeps filling a four-word local buffer from the source. When the response to the final data write has come back, `done_o` pulses for one cycle.

Top module: `cpw_issuer`

## Requirements
- R1: While reset is held and right after it, `req_valid_o`, `src_ready_o` and `done_o` are low and `rsp_ready_o` is high.
- R2: The first request of every command is a probe: `req_mask_o` is all zeros and `req_addr_o` is the command address. No data write is launched until the probe's response has arrived.
- R3: Every data write has `req_mask_o` all ones and goes to the address captured at start. The data words leave in the order the source delivered them.
- R4: The working credit is set to the value in each response minus the writes launched and not yet acknowledged, saturating at zero. It drops by one for every data write launched. No data write is launched at zero credit, so a target that reports its free space truthfully never overflows.
- R5: If the credit reaches zero while words remain, the next request is a probe. If a probe's response reports zero, another probe follows.
- R6: A command with length N produces exactly N data writes.
- R7: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its data and mask do not change.
- R8: `src_ready_o` is high only while a command runs, the four-word buffer has room, and fewer than N words have been accepted. The buffer keeps filling while the streamer waits for credit.
- R9: `done_o` is high for exactly one cycle, in the cycle after the final response is taken. A command with length 0 makes no request, and `done_o` pulses in the cycle after the start.
- R10: `rsp_ready_o` is high in every cycle.
- R11: A start pulse while a command is in progress is ignored. The running command keeps its address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a command when idle |
| len_i | input | LEN_W | Message length in words |
| addr_i | input | ADDR_W | Fixed destination address |
| src_valid_i | input | 1 | Source word valid |
| src_data_i | input | DATA_W | Source word |
| src_ready_o | output | 1 | Source word accepted when high with valid |
| req_valid_o | output | 1 | Write request valid |
| req_ready_i | input | 1 | Target accepts the request |
| req_addr_o | output | ADDR_W | Write address |
| req_data_o | output | DATA_W | Write data |
| req_mask_o | output | DATA_W/8 | Byte enables, all zero for a probe |
| rsp_valid_i | input | 1 | Write response valid |
| rsp_credit_i | input | CRED_W | Free words reported by the target |
| rsp_ready_o | output | 1 | Response accepted, always high |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on four things about the target:
- it answers only writes it has accepted;
- it answers them in acceptance order, one response per write;
- it never answers before acceptance;
- its credit never exceeds its real free space.

The bench's target model follows all four. It queues one response per accepted request with a fixed latency. It reports capacity minus occupancy, clipped to the credit width. Its occupancy only grows on accepted data writes and only shrinks through its own drain. Source words and start pulses are driven on the falling edge. A start pulse in the middle of a command is sent on purpose, to show that it has no effect.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_WAIT_PROBE,
    ST_SEND,
    ST_DRAIN
  } cpw_state_e;

  // Words still free after subtracting unacknowledged writes, floored at zero.
  function automatic int unsigned credit_left(int unsigned reported, int unsigned pending);
    return (reported > pending) ? reported - pending : 0;
  endfunction

  // Ring index advance with wrap at depth.
  function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/cpw_wbuf.sv
module cpw_wbuf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && wr_q == PTR_W'(i)) ent_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= PTR_W'(cpw_pkg::ring_next(32'(wr_q), DEPTH));
      if (pop_i)  rd_q <= PTR_W'(cpw_pkg::ring_next(32'(rd_q), DEPTH));
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign data_o  = ent_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  // R8
  buf_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R8
  buf_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/cpw_credit.sv
module cpw_credit #(
  parameter int CRED_W = 4,
  parameter int OUT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_data_i,
  input  logic              load_probe_i,
  input  logic              rsp_fire_i,
  input  logic [CRED_W-1:0] rsp_credit_i,
  output logic [CRED_W-1:0] cred_o,
  output logic [CRED_W-1:0] cred_next_o,
  output logic              probe_rsp_o,
  output logic              last_data_rsp_o
);
  logic [CRED_W-1:0] cred_q;
  logic [OUT_W-1:0]  out_q, out_next;
  logic              probe_q;
  logic              data_rsp;

  // Responses come back in order; the probe's answer is the one seen when no
  // data write is still outstanding ahead of it.
  assign probe_rsp_o     = rsp_fire_i && probe_q && (out_q == '0);
  assign data_rsp        = rsp_fire_i && !probe_rsp_o;
  assign last_data_rsp_o = data_rsp && (out_q == OUT_W'(1)) && !load_data_i;
  assign out_next        = out_q + OUT_W'(load_data_i) - OUT_W'(data_rsp);

  always_comb begin
    if (probe_rsp_o)      cred_next_o = rsp_credit_i;
    else if (data_rsp)    cred_next_o = CRED_W'(cpw_pkg::credit_left(32'(rsp_credit_i), 32'(out_next)));
    else if (load_data_i) cred_next_o = cred_q - CRED_W'(1);
    else                  cred_next_o = cred_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cred_q  <= '0;
      out_q   <= '0;
      probe_q <= 1'b0;
    end else if (clear_i) begin
      cred_q  <= '0;
      out_q   <= '0;
      probe_q <= 1'b0;
    end else begin
      cred_q <= cred_next_o;
      out_q  <= out_next;
      if (load_probe_i)     probe_q <= 1'b1;
      else if (probe_rsp_o) probe_q <= 1'b0;
    end
  end

  assign cred_o = cred_q;

  // R4
  credit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_data_i |-> cred_q != '0);
  // R2
  probe_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_data_i |-> !probe_q);
  // R6
  rsp_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fire_i |-> (out_q != '0 || probe_q));

endmodule

// File: rtl/cpw_issuer.sv
module cpw_issuer #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int CRED_W    = 4,
  parameter int BUF_DEPTH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 src_valid_i,
  input  logic [DATA_W-1:0]    src_data_i,
  output logic                 src_ready_o,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [ADDR_W-1:0]    req_addr_o,
  output logic [DATA_W-1:0]    req_data_o,
  output logic [DATA_W/8-1:0]  req_mask_o,
  input  logic                 rsp_valid_i,
  input  logic [CRED_W-1:0]    rsp_credit_i,
  output logic                 rsp_ready_o,
  output logic                 done_o
);
  import cpw_pkg::*;

  localparam int MASK_W = DATA_W / 8;
  localparam int OUT_W  = CRED_W + 1;

  cpw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, acc_q;
  logic              done_q;
  logic              slot_vld_q;
  logic [DATA_W-1:0] slot_data_q;
  logic [MASK_W-1:0] slot_mask_q;

  // Named internal events.
  logic busy, slot_free, start_go, start_nil, load_probe, load_data, src_push;
  logic buf_empty, buf_full;
  logic [DATA_W-1:0] buf_data;
  logic [CRED_W-1:0] cred, cred_next;
  logic probe_rsp, last_data_rsp;

  assign busy       = (state_q != ST_IDLE);
  assign slot_free  = !slot_vld_q || req_ready_i;
  assign start_go   = (state_q == ST_IDLE) && start_i && (len_i != '0);
  assign start_nil  = (state_q == ST_IDLE) && start_i && (len_i == '0);
  assign load_probe = (state_q == ST_PROBE) && slot_free;
  assign load_data  = (state_q == ST_SEND) && !buf_empty && (cred != '0) && slot_free;
  assign src_ready_o = busy && !buf_full && (acc_q != '0);
  assign src_push   = src_valid_i && src_ready_o;

  cpw_wbuf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) i_wbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (src_push),
    .data_i  (src_data_i),
    .pop_i   (load_data),
    .data_o  (buf_data),
    .empty_o (buf_empty),
    .full_o  (buf_full)
  );

  cpw_credit #(.CRED_W(CRED_W), .OUT_W(OUT_W)) i_credit (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .clear_i         (start_go),
    .load_data_i     (load_data),
    .load_probe_i    (load_probe),
    .rsp_fire_i      (rsp_valid_i),
    .rsp_credit_i    (rsp_credit_i),
    .cred_o          (cred),
    .cred_next_o     (cred_next),
    .probe_rsp_o     (probe_rsp),
    .last_data_rsp_o (last_data_rsp)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (start_go) state_d = ST_PROBE;
      ST_PROBE:      if (load_probe) state_d = ST_WAIT_PROBE;
      ST_WAIT_PROBE: if (probe_rsp) state_d = (rsp_credit_i == '0) ? ST_PROBE : ST_SEND;
      ST_SEND: begin
        if (load_data && rem_q == LEN_W'(1)) state_d = ST_DRAIN;
        else if (cred_next == '0)            state_d = ST_PROBE;
      end
      ST_DRAIN:      if (last_data_rsp) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      rem_q       <= '0;
      acc_q       <= '0;
      done_q      <= 1'b0;
      slot_vld_q  <= 1'b0;
      slot_data_q <= '0;
      slot_mask_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= start_nil || ((state_q == ST_DRAIN) && last_data_rsp);
      if (start_go) begin
        addr_q <= addr_i;
        rem_q  <= len_i;
        acc_q  <= len_i;
      end else begin
        if (load_data) rem_q <= rem_q - LEN_W'(1);
        if (src_push)  acc_q <= acc_q - LEN_W'(1);
      end
      if (slot_free) begin
        slot_vld_q  <= load_probe || load_data;
        slot_data_q <= load_data ? buf_data : '0;
        slot_mask_q <= load_data ? '1 : '0;
      end
    end
  end

  assign req_valid_o = slot_vld_q;
  assign req_addr_o  = addr_q;
  assign req_data_o  = slot_data_q;
  assign req_mask_o  = slot_mask_q;
  assign rsp_ready_o = 1'b1;
  assign done_o      = done_q;

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_data_o) && $stable(req_mask_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  mask_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_mask_o == '0 || req_mask_o == '1));
  // R11
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && start_i |=> $stable(req_addr_o));

endmodule

// File: tb/test_cpw_issuer.sv
module test_cpw_issuer;
  localparam int DW = 32, AW = 32, LW = 16, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [LW-1:0] len = '0;
  logic [AW-1:0] addr = '0;
  logic src_valid = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic src_ready, req_valid, req_ready, rsp_ready, done;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [DW/8-1:0] req_mask;
  logic rsp_valid = 1'b0;
  logic [CW-1:0] rsp_credit = '0;

  always #2 clk = ~clk;

  cpw_issuer i_cpw_issuer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .addr_i(addr),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_data_o(req_data), .req_mask_o(req_mask), .rsp_valid_i(rsp_valid),
    .rsp_credit_i(rsp_credit), .rsp_ready_o(rsp_ready), .done_o(done));

  int total = 0, bad = 0;
  logic [DW-1:0] exp_q[$];
  logic [AW-1:0] exp_addr;
  int rsp_due[$];
  int cyc = 0, cap = 6, occ = 0, drain_div = 3, drain_en = 1, ready_mode = 0;
  int n_data, n_probe, probes_first, first_probe, got_first;
  int acc_cnt, max_ahead, done_cnt = 0, last_rsp_cyc = -10, zero_mode = 0, prev_done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Target model and monitor: everything on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (done) begin
      done_cnt++;
      if (!zero_mode) chk(cyc == last_rsp_cyc + 1, "R9 done timing", cyc, last_rsp_cyc + 1);
      chk(!prev_done, "R9 single pulse", prev_done, 0);
    end
    prev_done = done;
    if (!rsp_ready) chk(0, "R10 rsp_ready", 0, 1);
    rsp_valid = 1'b0;
    if (rsp_due.size() > 0 && rsp_due[0] <= cyc) begin
      rsp_valid = 1'b1;
      rsp_credit = CW'((cap - occ > 15) ? 15 : cap - occ);
      void'(rsp_due.pop_front());
      if (rsp_due.size() == 0) last_rsp_cyc = cyc;
    end
    if (drain_en != 0 && occ > 0 && (cyc % drain_div) == 0) occ--;
    case (ready_mode)
      0: req_ready = 1'b1;
      1: req_ready = (cyc % 3) != 0;
      default: req_ready = (cyc % 5) < 2;
    endcase
    if (req_valid && req_ready) begin
      chk(req_addr == exp_addr, "R3/R11 address", req_addr, exp_addr);
      if (req_mask == '0) begin
        n_probe++;
        if (n_data == 0) probes_first++;
        if (!got_first) first_probe = 1;
      end else begin
        chk(req_mask == '1, "R3 full mask", req_mask, 15);
        chk(occ < cap, "R4 target overflow", occ, cap - 1);
        occ++;
        if (exp_q.size() == 0) chk(0, "R6 extra write", n_data + 1, n_data);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(req_data == e, "R3 data order", req_data, e);
        end
        n_data++;
      end
      got_first = 1;
      rsp_due.push_back(cyc + 2);
    end
    if (acc_cnt - n_data > max_ahead) max_ahead = acc_cnt - n_data;
  end

  // Scoreboard driver: expected words are queued before being offered.
  task automatic drive_src(int n, logic [DW-1:0] base, int gap);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] w;
      w = base + DW'(i) * 32'h0001_0003;
      exp_q.push_back(w);
      src_valid = 1'b1;
      src_data = w;
      while (!src_ready) @(negedge clk);
      acc_cnt++;
      @(negedge clk);
      src_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic pulse_start(int n, logic [AW-1:0] a);
    start = 1'b1; len = LW'(n); addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic prep(logic [AW-1:0] a);
    n_data = 0; n_probe = 0; probes_first = 0; first_probe = 0; got_first = 0;
    acc_cnt = 0; max_ahead = 0; exp_addr = a;
  endtask

  task automatic finish_msg(int n, int k);
    wait (done_cnt == k);
    chk(n_data == n, "R6 write count", n_data, n);
    chk(first_probe == 1, "R2 probe first", first_probe, 1);
    chk(exp_q.size() == 0, "R3 all words sent", exp_q.size(), 0);
    chk(!src_ready && !req_valid, "R8 idle after done", src_ready, 0);
  endtask

  task automatic run_msg(int n, logic [AW-1:0] a, logic [DW-1:0] base, int gap, int k);
    prep(a);
    fork
      pulse_start(n, a);
      drive_src(n, base, gap);
    join
    finish_msg(n, k);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_valid && !src_ready && !done && rsp_ready, "R1 in reset", req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !src_ready && !done && rsp_ready, "R1 after reset", src_ready, 0);

    // Plain stream, generous target.
    cap = 6; drain_div = 3; ready_mode = 0;
    run_msg(10, 32'h4000_0010, 32'h1000_0000, 0, 1);

    // Tight credit, stalling ready, source gaps: many refill probes.
    cap = 3; drain_div = 4; ready_mode = 1;
    run_msg(23, 32'h4000_0020, 32'h2000_0000, 1, 2);
    chk(n_probe >= 2, "R5 refill probes", n_probe, 2);

    // Single word.
    cap = 8; drain_div = 2; ready_mode = 2;
    run_msg(1, 32'h4000_0030, 32'h3000_0000, 0, 3);

    // Target full at start: zero-credit probes repeat; buffer fills meanwhile.
    @(negedge clk);
    cap = 4; occ = 4; drain_en = 0; drain_div = 2; ready_mode = 0;
    prep(32'h4000_0040);
    fork
      pulse_start(12, 32'h4000_0040);
      drive_src(12, 32'h4000_0000, 0);
      begin repeat (40) @(negedge clk); drain_en = 1; end
    join
    finish_msg(12, 4);
    chk(probes_first >= 2, "R5 zero credit reprobe", probes_first, 2);
    chk(max_ahead >= 4 && max_ahead <= 5, "R8 buffer fills while paused", max_ahead, 4);

    // Start during a running command must be ignored.
    cap = 5; drain_div = 2; ready_mode = 1;
    prep(32'h4000_0050);
    fork
      pulse_start(8, 32'h4000_0050);
      drive_src(8, 32'h5000_0000, 2);
      begin repeat (10) @(negedge clk); pulse_start(99, 32'h7777_0000); end
    join
    finish_msg(8, 5);
    repeat (6) @(negedge clk);
    chk(!req_valid && n_data == 8, "R11 stray start ignored", n_data, 8);

    // Zero-length command.
    zero_mode = 1;
    start = 1'b1; len = '0; addr = 32'h4000_0060;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R9 zero length done", done, 1);
    chk(!req_valid, "R9 zero length no request", req_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 zero length pulse ends", done, 0);
    chk(!req_valid, "R9 zero length still no request", req_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule